// File: doc/BRIEF.md
# Pre-Increment Stack Pointer Unit

This block owns the 8-bit stack pointer of a small processor core and the 128-byte internal data RAM that the stack lives in. The core sends one-cycle strobes: a single-byte push or pop, a call-style push of a 16-bit return address, a return-style pop of one, or a direct load of the pointer. The unit forms the RAM address, write enable and write data in the order the stack discipline needs. It returns popped bytes and popped return addresses with a valid flag.

A push advances the pointer and then writes at the new location. A pop reads the location the pointer names and then steps it back. The pointer comes out of reset at 07h, so the first pushed byte lands at 08h. Two-byte operations take two cycles. During the second cycle the unit raises busy and drops every new strobe. The pointer wraps modulo 256. Any access whose address is at or above the end of the RAM is flagged instead of being carried out.

Top module: `stack_ptr_unit`

## Requirements
- R1: During synchronous active-low reset and after it, the pointer reads 07h, busy, pop_valid, ret_valid and range_err are low, and every RAM byte holds 00h.
- R2: A push strobe accepted while idle raises the pointer by one at the next clock edge and writes push_data at the new pointer value.
- R3: A pop strobe accepted while idle sets pop_valid for one cycle after the next edge, with pop_data equal to the byte at the pointer as it stood before the strobe, and lowers the pointer by one. Popped bytes come back in reverse order of pushing.
- R4: The first byte pushed after reset is stored at address 08h, and the pointer then reads 08h.
- R5: A call strobe writes ret_addr bits 7:0 at pointer+1 and, one cycle later, ret_addr bits 15:8 at pointer+2. The pointer ends two higher, and busy is high for exactly the second cycle.
- R6: A return strobe reads the high byte at the pointer and then the low byte at pointer−1. ret_valid is high for one cycle after the second edge, with ret_data = {high, low}, and the pointer ends two lower.
- R7: A pointer load while idle sets the pointer to sp_wdata at the next edge and overrides any strobe in the same cycle. Among the other strobes the priority is call, then return, then push, then pop.
- R8: While busy is high, push, pop, call, return and load strobes all have no effect.
- R9: The pointer wraps modulo 256 in both directions, with no error indication. A push at FFh stores at 00h.
- R10: An access at an address of 80h or above writes nothing and reads 00h, and range_err is high for the one cycle after that access.
- R11: busy never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sp_wr | input | 1 | Load strobe for the pointer |
| sp_wdata | input | 8 | Value to load into the pointer |
| push_req | input | 1 | Single-byte push strobe |
| push_data | input | 8 | Byte to push |
| pop_req | input | 1 | Single-byte pop strobe |
| call_req | input | 1 | Two-byte return-address push strobe |
| ret_addr | input | 16 | Return address to push |
| ret_req | input | 1 | Two-byte return-address pop strobe |
| sp | output | 8 | Current stack pointer |
| busy | output | 1 | Second step of a two-byte operation is in progress |
| pop_valid | output | 1 | pop_data holds a popped byte |
| pop_data | output | 8 | Popped byte |
| ret_valid | output | 1 | ret_data holds a popped return address |
| ret_data | output | 16 | Popped return address |
| range_err | output | 1 | Previous access addressed past the RAM |

## Verification
The properties assume that the strobes are synchronous single-cycle pulses, and that a strobe raised during a busy cycle is simply lost rather than held until accepted. They check the pointer step only when a strobe wins arbitration, so they take the stated priority order as given. The directed stimulus raises strobes for one cycle at a time on the falling edge. It deliberately overlaps strobes and raises them in busy cycles. A random phase draws strobes independently every cycle, which covers the overlap and busy cases without ever holding a strobe on purpose.

// File: rtl/stkp_pkg.sv
// Package: shared types for the stack pointer unit.
// Assumes: a single clock domain; one step is carried out per cycle.
package stkp_pkg;

    // Sequencer state: idle, or waiting for the second step of a pair.
    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_CALL_HI = 2'd1,
        SEQ_RET_LO  = 2'd2
    } seq_state_t;

    // Step the unit performs in the current cycle.
    typedef enum logic [2:0] {
        STEP_NONE    = 3'd0,
        STEP_LOAD    = 3'd1,
        STEP_CALL_LO = 3'd2,
        STEP_RET_HI  = 3'd3,
        STEP_PUSH    = 3'd4,
        STEP_POP     = 3'd5,
        STEP_CALL_HI = 3'd6,
        STEP_RET_LO  = 3'd7
    } step_t;

endpackage

// File: rtl/stkp_sel.sv
// Module: stkp_sel
// Picks the step for this cycle. A pending second step always wins.
// When idle, the order is load, call, return, push, pop.
// Assumes: strobes are one cycle wide and are dropped if not taken.
module stkp_sel
    import stkp_pkg::*;
(
    input  seq_state_t state,
    input  logic       sp_wr,
    input  logic       call_req,
    input  logic       ret_req,
    input  logic       push_req,
    input  logic       pop_req,
    output step_t      step
);

    // Fixed-priority choice of the step to perform.
    always_comb begin
        unique case (state)
            SEQ_CALL_HI: step = STEP_CALL_HI;
            SEQ_RET_LO:  step = STEP_RET_LO;
            default: begin
                if (sp_wr)         step = STEP_LOAD;
                else if (call_req) step = STEP_CALL_LO;
                else if (ret_req)  step = STEP_RET_HI;
                else if (push_req) step = STEP_PUSH;
                else if (pop_req)  step = STEP_POP;
                else               step = STEP_NONE;
            end
        endcase
    end

endmodule

// File: rtl/stkp_core.sv
// Module: stkp_core
// Holds the pointer, the sequencer state and the saved high byte.
// It drives the RAM address and data so that writes go to pointer+1
// and reads come from the pointer.
// Assumes: rdata is the combinational read of mem_addr in the same cycle.
module stkp_core
    import stkp_pkg::*;
#(
    parameter int          PW     = 8,
    parameter int          DW     = 8,
    parameter logic [PW-1:0] RST_SP = 8'h07
) (
    input  logic            clk,
    input  logic            rst_n,
    input  step_t           step,
    input  logic [PW-1:0]   sp_wdata,
    input  logic [DW-1:0]   push_data,
    input  logic [2*DW-1:0] ret_addr,
    input  logic [DW-1:0]   rdata,
    output logic [PW-1:0]   sp,
    output seq_state_t      state,
    output logic [DW-1:0]   hi_q,
    output logic            mem_we,
    output logic            mem_re,
    output logic [PW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata
);

    localparam logic [PW-1:0] ONE = PW'(1);

    logic [PW-1:0] sp_up;
    logic [PW-1:0] sp_dn;
    logic [PW-1:0] sp_nxt;
    seq_state_t    state_nxt;
    logic          is_write;

    assign sp_up = sp + ONE;
    assign sp_dn = sp - ONE;

    // Classify the step as a write, a read, or neither.
    always_comb begin
        is_write = (step == STEP_PUSH) || (step == STEP_CALL_LO) || (step == STEP_CALL_HI);
        mem_re   = (step == STEP_POP)  || (step == STEP_RET_HI)  || (step == STEP_RET_LO);
        mem_we   = is_write;
    end

    // Address: writes use the advanced pointer, reads the current one.
    always_comb begin
        mem_addr = is_write ? sp_up : sp;
    end

    // Select the byte written by push and by both halves of a call.
    always_comb begin
        unique case (step)
            STEP_CALL_LO: mem_wdata = ret_addr[DW-1:0];
            STEP_CALL_HI: mem_wdata = hi_q;
            default:      mem_wdata = push_data;
        endcase
    end

    // Next pointer and next sequencer state.
    always_comb begin
        sp_nxt    = sp;
        state_nxt = SEQ_IDLE;
        unique case (step)
            STEP_LOAD:    sp_nxt = sp_wdata;
            STEP_PUSH:    sp_nxt = sp_up;
            STEP_CALL_HI: sp_nxt = sp_up;
            STEP_POP:     sp_nxt = sp_dn;
            STEP_RET_LO:  sp_nxt = sp_dn;
            STEP_CALL_LO: begin
                sp_nxt    = sp_up;
                state_nxt = SEQ_CALL_HI;
            end
            STEP_RET_HI: begin
                sp_nxt    = sp_dn;
                state_nxt = SEQ_RET_LO;
            end
            default: sp_nxt = sp;
        endcase
    end

    // Pointer and state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp    <= RST_SP;
            state <= SEQ_IDLE;
        end else begin
            sp    <= sp_nxt;
            state <= state_nxt;
        end
    end

    // Saved high byte: taken from ret_addr on a call, from RAM on a return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else if (step == STEP_CALL_LO) begin
            hi_q <= ret_addr[2*DW-1:DW];
        end else if (step == STEP_RET_HI) begin
            hi_q <= rdata;
        end
    end

endmodule

// File: rtl/stkp_ram.sv
// Module: stkp_ram
// Internal data RAM with a combinational read and a clocked write.
// Addresses at or past DEPTH are not stored. Reads there return zero,
// and oob flags the access.
// Assumes: DEPTH <= 2**AW; the contents clear on reset.
module stkp_ram #(
    parameter int AW    = 8,
    parameter int DW    = 8,
    parameter int DEPTH = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          oob
);

    localparam int          IDXW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic          in_rng;
    logic [IDXW-1:0] idx;

    assign in_rng = ({1'b0, addr} < LIMIT);
    assign idx    = addr[IDXW-1:0];

    // Flag any access that falls outside the array.
    always_comb begin
        oob = (we || re) && !in_rng;
    end

    // Combinational read that returns zero when out of range.
    always_comb begin
        rdata = in_rng ? mem[idx] : '0;
    end

    // Clear on reset; write only in-range addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we && in_rng) begin
            mem[idx] <= wdata;
        end
    end

endmodule

// File: rtl/stkp_rdcap.sv
// Module: stkp_rdcap
// Registers the results the core sees: popped bytes, assembled
// return addresses and the range flag. Each is valid for one cycle.
// Assumes: hi_q already holds the high byte when the low-byte step runs.
module stkp_rdcap
    import stkp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  step_t           step,
    input  logic [DW-1:0]   rdata,
    input  logic [DW-1:0]   hi_q,
    input  logic            oob,
    output logic            pop_valid,
    output logic [DW-1:0]   pop_data,
    output logic            ret_valid,
    output logic [2*DW-1:0] ret_data,
    output logic            range_err
);

    // One-cycle valid and range pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_valid <= 1'b0;
            ret_valid <= 1'b0;
            range_err <= 1'b0;
        end else begin
            pop_valid <= (step == STEP_POP);
            ret_valid <= (step == STEP_RET_LO);
            range_err <= oob;
        end
    end

    // Data registers hold their value until the next result arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_data <= '0;
            ret_data <= '0;
        end else begin
            if (step == STEP_POP)    pop_data <= rdata;
            if (step == STEP_RET_LO) ret_data <= {hi_q, rdata};
        end
    end

endmodule

// File: rtl/stack_ptr_unit.sv
// Module: stack_ptr_unit
// Top of the stack pointer unit. It joins the step selector, the pointer
// core, the data RAM and the result registers. busy reflects the
// pending second step of a call or return.
// Assumes: strobes are single-cycle pulses from the core, and any that
// arrive while busy are lost.
module stack_ptr_unit
    import stkp_pkg::*;
#(
    parameter int            PW     = 8,
    parameter int            DW     = 8,
    parameter int            DEPTH  = 128,
    parameter logic [PW-1:0] RST_SP = 8'h07
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sp_wr,
    input  logic [PW-1:0]   sp_wdata,
    input  logic            push_req,
    input  logic [DW-1:0]   push_data,
    input  logic            pop_req,
    input  logic            call_req,
    input  logic [2*DW-1:0] ret_addr,
    input  logic            ret_req,
    output logic [PW-1:0]   sp,
    output logic            busy,
    output logic            pop_valid,
    output logic [DW-1:0]   pop_data,
    output logic            ret_valid,
    output logic [2*DW-1:0] ret_data,
    output logic            range_err
);

    seq_state_t    state;
    step_t         step;
    logic [DW-1:0] hi_q;
    logic          mem_we;
    logic          mem_re;
    logic [PW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] rdata;
    logic          oob;

    // Busy whenever a second step is pending.
    assign busy = (state != SEQ_IDLE);

    stkp_sel u_sel (
        .state    (state),
        .sp_wr    (sp_wr),
        .call_req (call_req),
        .ret_req  (ret_req),
        .push_req (push_req),
        .pop_req  (pop_req),
        .step     (step)
    );

    stkp_core #(
        .PW     (PW),
        .DW     (DW),
        .RST_SP (RST_SP)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .sp_wdata  (sp_wdata),
        .push_data (push_data),
        .ret_addr  (ret_addr),
        .rdata     (rdata),
        .sp        (sp),
        .state     (state),
        .hi_q      (hi_q),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    stkp_ram #(
        .AW    (PW),
        .DW    (DW),
        .DEPTH (DEPTH)
    ) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .re    (mem_re),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (rdata),
        .oob   (oob)
    );

    stkp_rdcap #(
        .DW (DW)
    ) u_rdcap (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .rdata     (rdata),
        .hi_q      (hi_q),
        .oob       (oob),
        .pop_valid (pop_valid),
        .pop_data  (pop_data),
        .ret_valid (ret_valid),
        .ret_data  (ret_data),
        .range_err (range_err)
    );

endmodule

// File: rtl/stkp_checker.sv
// Module: stkp_checker
// Port-level properties of the stack pointer unit, bound to the top.
// Assumes: strobes are single-cycle pulses; properties are checked only
// on strobes that win arbitration.
module stkp_checker #(
    parameter int PW = 8,
    parameter int DW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sp_wr,
    input logic [PW-1:0]   sp_wdata,
    input logic            push_req,
    input logic            pop_req,
    input logic            call_req,
    input logic            ret_req,
    input logic [PW-1:0]   sp,
    input logic            busy,
    input logic            pop_valid,
    input logic            ret_valid
);

    // Leaving reset, the pointer is at its reset value and the unit is idle.
    assert_reset_value_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (sp == PW'(8'h07) && !busy && !pop_valid && !ret_valid));

    assert_push_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && push_req && !sp_wr && !call_req && !ret_req)
        |=> (sp == $past(sp) + PW'(1)));

    assert_pop_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && pop_req && !sp_wr && !call_req && !ret_req && !push_req)
        |=> (pop_valid && sp == $past(sp) - PW'(1)));

    assert_single_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pop_valid, ret_valid}));

    assert_call_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && call_req && !sp_wr) |=> busy);

    assert_ret_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ret_req && !sp_wr && !call_req) |=> ##1 ret_valid);

    assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sp_wr) |=> (sp == $past(sp_wdata)));

    assert_busy_short_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

endmodule

bind stack_ptr_unit stkp_checker #(
    .PW (PW),
    .DW (DW)
) u_stkp_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .sp_wr     (sp_wr),
    .sp_wdata  (sp_wdata),
    .push_req  (push_req),
    .pop_req   (pop_req),
    .call_req  (call_req),
    .ret_req   (ret_req),
    .sp        (sp),
    .busy      (busy),
    .pop_valid (pop_valid),
    .ret_valid (ret_valid)
);

// File: tb/stack_ptr_unit_bench.sv
// Bench for stack_ptr_unit. A behavioural model is updated on each rising
// edge and compared with the outputs on every falling edge. Directed
// checks cover the corner cases, then a random phase follows.
module stack_ptr_unit_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sp_wr = 1'b0;
    logic [7:0]  sp_wdata = '0;
    logic        push_req = 1'b0;
    logic [7:0]  push_data = '0;
    logic        pop_req = 1'b0;
    logic        call_req = 1'b0;
    logic [15:0] ret_addr = '0;
    logic        ret_req = 1'b0;
    logic [7:0]  sp;
    logic        busy;
    logic        pop_valid;
    logic [7:0]  pop_data;
    logic        ret_valid;
    logic [15:0] ret_data;
    logic        range_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stack_ptr_unit u_stack_ptr_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .sp_wr     (sp_wr),
        .sp_wdata  (sp_wdata),
        .push_req  (push_req),
        .push_data (push_data),
        .pop_req   (pop_req),
        .call_req  (call_req),
        .ret_addr  (ret_addr),
        .ret_req   (ret_req),
        .sp        (sp),
        .busy      (busy),
        .pop_valid (pop_valid),
        .pop_data  (pop_data),
        .ret_valid (ret_valid),
        .ret_data  (ret_data),
        .range_err (range_err)
    );

    // Reference model state
    int m_sp = 7;
    int m_phase = 0;
    int m_hi = 0;
    int m_mem[128];
    int e_pv = 0, e_pd = 0, e_rv = 0, e_rd = 0, e_re = 0;

    function automatic int m_read(int a, inout int re);
        if (a < 128) return m_mem[a];
        re = 1;
        return 0;
    endfunction

    task automatic m_write(int a, int d, inout int re);
        if (a < 128) m_mem[a] = d;
        else re = 1;
    endtask

    // Model update on each rising edge, from the requirements
    always @(posedge clk) begin
        int re;
        int lo;
        int a;
        if (!rst_n) begin
            m_sp = 7; m_phase = 0; m_hi = 0;
            foreach (m_mem[i]) m_mem[i] = 0;
            e_pv = 0; e_pd = 0; e_rv = 0; e_rd = 0; e_re = 0;
        end else begin
            re = 0; e_pv = 0; e_rv = 0;
            if (m_phase == 1) begin
                a = (m_sp + 1) % 256; m_write(a, m_hi, re); m_sp = a; m_phase = 0;
            end else if (m_phase == 2) begin
                lo = m_read(m_sp, re); e_rd = m_hi * 256 + lo; e_rv = 1;
                m_sp = (m_sp + 255) % 256; m_phase = 0;
            end else if (sp_wr) begin
                m_sp = sp_wdata;
            end else if (call_req) begin
                a = (m_sp + 1) % 256; m_write(a, ret_addr[7:0], re);
                m_hi = ret_addr[15:8]; m_sp = a; m_phase = 1;
            end else if (ret_req) begin
                m_hi = m_read(m_sp, re); m_sp = (m_sp + 255) % 256; m_phase = 2;
            end else if (push_req) begin
                a = (m_sp + 1) % 256; m_write(a, push_data, re); m_sp = a;
            end else if (pop_req) begin
                e_pd = m_read(m_sp, re); e_pv = 1; m_sp = (m_sp + 255) % 256;
            end
            e_re = re;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison on the falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2/R3/R9 sp", sp, m_sp);
            chk("R5/R11 busy", busy, m_phase != 0);
            chk("R3 pop_valid", pop_valid, e_pv);
            if (e_pv) chk("R3 pop_data", pop_data, e_pd);
            chk("R6 ret_valid", ret_valid, e_rv);
            if (e_rv) chk("R6 ret_data", ret_data, e_rd);
            chk("R10 range_err", range_err, e_re);
        end
    end

    task automatic clr();
        sp_wr = 0; push_req = 0; pop_req = 0; call_req = 0; ret_req = 0;
    endtask
    task automatic do_push(logic [7:0] d);
        push_req = 1; push_data = d; @(negedge clk); clr();
    endtask
    task automatic do_pop();
        pop_req = 1; @(negedge clk); clr();
    endtask
    task automatic do_load(logic [7:0] v);
        sp_wr = 1; sp_wdata = v; @(negedge clk); clr();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 sp in reset", sp, 8'h07);
        chk("R1 busy in reset", busy, 0);
        chk("R1 valid in reset", {pop_valid, ret_valid, range_err}, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 sp after reset", sp, 8'h07);

        // R4: first push lands at 08h
        do_push(8'hAA);
        chk("R4 sp after first push", sp, 8'h08);
        chk("R2 sp advanced", sp, 8'h08);
        do_pop();
        chk("R3 pop_valid", pop_valid, 1);
        chk("R4 byte from 08h", pop_data, 8'hAA);
        chk("R3 sp after pop", sp, 8'h07);

        // R3: LIFO order
        do_push(8'h11); do_push(8'h22); do_push(8'h33);
        do_pop(); chk("R3 lifo 1", pop_data, 8'h33);
        do_pop(); chk("R3 lifo 2", pop_data, 8'h22);
        do_pop(); chk("R3 lifo 3", pop_data, 8'h11);

        // R5 and R8: call, with strobes during the busy cycle
        call_req = 1; ret_addr = 16'h1234; @(negedge clk); clr();
        chk("R5 busy second cycle", busy, 1);
        push_req = 1; push_data = 8'h77; sp_wr = 1; sp_wdata = 8'h50;
        @(negedge clk); clr();
        chk("R8 sp ignores strobes while busy", sp, 8'h09);
        chk("R11 busy dropped", busy, 0);
        // R6: return
        ret_req = 1; @(negedge clk); clr();
        chk("R6 busy during return", busy, 1);
        @(negedge clk);
        chk("R6 ret_valid", ret_valid, 1);
        chk("R6 ret_data", ret_data, 16'h1234);
        chk("R6 sp restored", sp, 8'h07);

        // R5: byte order in RAM seen through single pops
        call_req = 1; ret_addr = 16'hBEEF; @(negedge clk); clr(); @(negedge clk);
        do_pop(); chk("R5 high byte on top", pop_data, 8'hBE);
        do_pop(); chk("R5 low byte below", pop_data, 8'hEF);

        // R7: load overrides push; call beats push
        sp_wr = 1; sp_wdata = 8'h40; push_req = 1; push_data = 8'h99;
        @(negedge clk); clr();
        chk("R7 load wins", sp, 8'h40);
        do_load(8'h41); do_pop();
        chk("R7 push was dropped", pop_data, 8'h00);
        call_req = 1; ret_addr = 16'h0102; push_req = 1; @(negedge clk); clr(); @(negedge clk);
        chk("R7 call beats push", sp, 8'h42);

        // R9: wrap upward and downward
        do_load(8'hFF); do_push(8'h5A);
        chk("R9 wrap up", sp, 8'h00);
        do_pop(); chk("R9 data at 00h", pop_data, 8'h5A);
        chk("R9 wrap down", sp, 8'hFF);

        // R10: out-of-range access
        do_load(8'h7F); do_push(8'hC3);
        chk("R10 range_err on write", range_err, 1);
        chk("R10 sp still moves", sp, 8'h80);
        do_pop();
        chk("R10 read gives 00h", pop_data, 8'h00);
        chk("R10 range_err on read", range_err, 1);
        @(negedge clk);
        chk("R10 pulse one cycle", range_err, 0);
        do_load(8'h7E);
        call_req = 1; ret_addr = 16'hA55A; @(negedge clk); clr(); @(negedge clk);
        chk("R10 high half out of range", range_err, 1);

        // Random phase, compared by the model every cycle
        for (int n = 0; n < 2000; n++) begin
            sp_wr     = ($urandom_range(0, 15) == 0);
            sp_wdata  = ($urandom_range(0, 1) == 0) ? 8'($urandom_range(0, 127)) : 8'($urandom);
            push_req  = ($urandom_range(0, 2) == 0);
            push_data = 8'($urandom);
            pop_req   = ($urandom_range(0, 2) == 0);
            call_req  = ($urandom_range(0, 7) == 0);
            ret_req   = ($urandom_range(0, 7) == 0);
            ret_addr  = 16'($urandom);
            @(negedge clk);
        end
        clr();
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule